// File: doc/BRIEF.md
# Link Endpoint Power-State Controller

This block sequences the power states of one end of a serial display link. A chip-level active-low reset request passes through a stability filter. The filtered request, together with the endpoint role, drives a four-state machine: off, oscillator warm-up, running and sleep. On the transmitting (master) endpoint, a standby pin chooses between sleep and running. On the receiving (slave) endpoint, sleep is entered and left on single-cycle indications decoded from the link. The standby pin has no effect there.

The block gates strobes until a warm-up counter expires. The wait is longer after reset than after sleep. Strobes that arrive too early are dropped and flagged. The block also decides what the parallel port shows in each state. The master stops driving in off and sleep. The slave drives zeros with write clocks high in off, and in sleep it freezes the last data and control values with write clocks high. The oscillator itself and analog power gating are outside the block; it provides an oscillator enable and a ready flag. All inputs are taken as synchronous to the reference clock.

Top module: `lpc_top`

## Requirements
- R1: While the filtered reset request is low, the state is off: `ready` and `osc_en` are 0, whatever `stby_n`, `link_sleep` or `link_wake` do. The state is entered one cycle after the filtered request falls.
- R2: A change on `res_n` reaches the filtered request only after the new level has been sampled on FILT_CYC consecutive clock edges. A pulse lasting FILT_CYC-1 samples has no effect.
- R3: On the master (`is_master`=1) with the filtered request high: `stby_n`=0 selects sleep one cycle later, and `stby_n`=1 leads through warm-up to running. `link_wake` is ignored.
- R4: On the slave (`is_master`=0), `stby_n` is ignored. A one-cycle `link_sleep` moves the running state to sleep, and a one-cycle `link_wake` moves sleep to warm-up.
- R5: On the master, `out_en`=0 and `dat_out`, `ctl_out` and `wclk_out` are all zero in off and sleep. In warm-up and running, `out_en`=1.
- R6: On the slave in off, `out_en`=1, `dat_out` and `ctl_out` are 0, and every bit of `wclk_out` is 1.
- R7: On the slave in sleep, `dat_out` and `ctl_out` hold the values of `dat_in` and `ctl_in` sampled on the edge that entered sleep, and every bit of `wclk_out` is 1.
- R8: Warm-up lasts exactly RES_WAIT_CYC cycles when entered from off, and exactly STBY_WAIT_CYC cycles when entered from sleep. `ready` is 1 only in running.
- R9: A strobe while `ready`=0 gives `strobe_early`=1 and `strobe_ok`=0 in the same cycle. While `ready`=1 it gives `strobe_ok`=1 and `strobe_early`=0.
- R10: `osc_en` is 1 in warm-up and running and 0 in off and sleep.
- R11: In warm-up and running, `dat_out`, `ctl_out` and `wclk_out` follow `dat_in`, `ctl_in` and `wclk_in` combinationally, on both roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the controller flops |
| is_master | input | 1 | Endpoint role: 1 master, 0 slave; static |
| res_n | input | 1 | Active-low reset request, filtered |
| stby_n | input | 1 | Active-low standby request (master only) |
| link_sleep | input | 1 | One-cycle sleep indication from link decode (slave) |
| link_wake | input | 1 | One-cycle wake indication from link activity (slave) |
| strobe_in | input | 1 | One-cycle strobe request |
| dat_in | input | DATA_W | Parallel data from the datapath |
| ctl_in | input | CTRL_W | Control bits from the datapath |
| wclk_in | input | NWCLK | Write clocks from the datapath |
| strobe_ok | output | 1 | Strobe accepted |
| strobe_early | output | 1 | Strobe dropped because not ready |
| ready | output | 1 | Running; strobes accepted |
| osc_en | output | 1 | Oscillator enable |
| out_en | output | 1 | Parallel port drive enable |
| dat_out | output | DATA_W | Parallel data after state forcing |
| ctl_out | output | CTRL_W | Control bits after state forcing |
| wclk_out | output | NWCLK | Write clocks after state forcing |

## Verification
The bench measures both warm-up lengths to the exact cycle. A controller that used the wrong count, or that released strobes one cycle early, would raise `ready` at a visibly different edge. It sends a reset pulse one sample shorter than the filter window, which a filter that is off by one would wrongly pass. It then sends a pulse exactly as long as the window, and checks that the state drops on the following edge. It changes `dat_in` on the same edge that enters slave sleep, so a hold register loaded at the wrong time shows the new value. It also drives the pin and link indications on the role that must ignore them.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_WAKE  = 2'd1,
        PS_RUN   = 2'd2,
        PS_SLEEP = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic load;
        logic from_off;
    } timer_cmd_t;

    function automatic logic port_live(input pwr_state_e s);
        return (s == PS_WAKE) || (s == PS_RUN);
    endfunction

endpackage

// File: rtl/lpc_deglitch.sv
module lpc_deglitch #(
    parameter int STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt    <= 1'b0;
            run_len <= '0;
        end else if (raw == filt) begin
            run_len <= '0;
        end else if (run_len == LAST) begin
            filt    <= raw;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2: a new filtered level must have been present on the raw input
    p_filt_follows_raw_r2: assert property (@(posedge clk) disable iff (rst)
        (filt != $past(filt)) |-> ($past(raw) == filt));

endmodule

// File: rtl/lpc_wake_timer.sv
module lpc_wake_timer
    import lpc_pkg::*;
#(
    parameter int RES_WAIT  = 48,
    parameter int STBY_WAIT = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  timer_cmd_t cmd,
    output logic       done
);
    localparam int MAXW = (RES_WAIT > STBY_WAIT) ? RES_WAIT : STBY_WAIT;
    localparam int TW   = $clog2(MAXW + 1);
    localparam logic [TW-1:0] RES_LOAD  = TW'(RES_WAIT - 1);
    localparam logic [TW-1:0] STBY_LOAD = TW'(STBY_WAIT - 1);

    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (cmd.load) begin
            left <= cmd.from_off ? RES_LOAD : STBY_LOAD;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign done = (left == '0);

endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
    import lpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_master,
    input  logic       res_ok,
    input  logic       stby_n,
    input  logic       link_sleep,
    input  logic       link_wake,
    input  logic       wait_done,
    output pwr_state_e state,
    output timer_cmd_t tcmd
);
    pwr_state_e nxt;
    logic       sleep_req;
    logic       wake_req;

    assign sleep_req = is_master ? ~stby_n : link_sleep;
    assign wake_req  = is_master ?  stby_n : link_wake;

    always_comb begin
        nxt = state;
        if (!res_ok) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:   nxt = (is_master && !stby_n) ? PS_SLEEP : PS_WAKE;
                PS_WAKE:  begin
                    if (sleep_req)      nxt = PS_SLEEP;
                    else if (wait_done) nxt = PS_RUN;
                end
                PS_RUN:   if (sleep_req) nxt = PS_SLEEP;
                PS_SLEEP: if (wake_req)  nxt = PS_WAKE;
                default:  nxt = PS_OFF;
            endcase
        end
    end

    assign tcmd.load     = (nxt == PS_WAKE) && (state != PS_WAKE);
    assign tcmd.from_off = (state == PS_OFF);

    always_ff @(posedge clk) begin
        if (rst) state <= PS_OFF;
        else     state <= nxt;
    end

    // R4: the slave keeps running unless the link asks for sleep
    p_slave_pin_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!is_master && state == PS_RUN && !link_sleep && res_ok) |=> (state == PS_RUN));

endmodule

// File: rtl/lpc_out_force.sv
module lpc_out_force
    import lpc_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int CTRL_W = 8,
    parameter int NWCLK  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  pwr_state_e        state,
    input  logic [DATA_W-1:0] dat_in,
    input  logic [CTRL_W-1:0] ctl_in,
    input  logic [NWCLK-1:0]  wclk_in,
    output logic [DATA_W-1:0] dat_out,
    output logic [CTRL_W-1:0] ctl_out,
    output logic [NWCLK-1:0]  wclk_out,
    output logic              out_en
);
    localparam int HW = DATA_W + CTRL_W;

    logic          live;
    logic [HW-1:0] held;

    assign live = port_live(state);

    always_ff @(posedge clk) begin
        if (rst || state == PS_OFF) held <= '0;
        else if (live)              held <= {dat_in, ctl_in};
    end

    always_comb begin
        if (live) begin
            dat_out = dat_in;
            ctl_out = ctl_in;
        end else if (is_master || state == PS_OFF) begin
            dat_out = '0;
            ctl_out = '0;
        end else begin
            dat_out = held[HW-1:CTRL_W];
            ctl_out = held[CTRL_W-1:0];
        end
    end

    assign out_en = live || !is_master;

    for (genvar i = 0; i < NWCLK; i++) begin : g_wclk
        assign wclk_out[i] = live ? wclk_in[i] : !is_master;
    end

    // R7: the slave port is frozen throughout sleep
    p_slave_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!is_master && state == PS_SLEEP && $past(state) == PS_SLEEP)
            |-> ($stable(dat_out) && $stable(ctl_out)));

endmodule

// File: rtl/lpc_top.sv
module lpc_top
    import lpc_pkg::*;
#(
    parameter int DATA_W        = 18,
    parameter int CTRL_W        = 8,
    parameter int NWCLK         = 2,
    parameter int FILT_CYC      = 8,
    parameter int RES_WAIT_CYC  = 48,
    parameter int STBY_WAIT_CYC = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              res_n,
    input  logic              stby_n,
    input  logic              link_sleep,
    input  logic              link_wake,
    input  logic              strobe_in,
    input  logic [DATA_W-1:0] dat_in,
    input  logic [CTRL_W-1:0] ctl_in,
    input  logic [NWCLK-1:0]  wclk_in,
    output logic              strobe_ok,
    output logic              strobe_early,
    output logic              ready,
    output logic              osc_en,
    output logic              out_en,
    output logic [DATA_W-1:0] dat_out,
    output logic [CTRL_W-1:0] ctl_out,
    output logic [NWCLK-1:0]  wclk_out
);
    localparam int MAXW = (RES_WAIT_CYC > STBY_WAIT_CYC) ? RES_WAIT_CYC : STBY_WAIT_CYC;
    localparam int TW   = $clog2(MAXW + 1);
    localparam logic [TW-1:0] RES_LAST  = TW'(RES_WAIT_CYC - 1);
    localparam logic [TW-1:0] STBY_LAST = TW'(STBY_WAIT_CYC - 1);

    logic       res_f;
    logic       wait_done;
    pwr_state_e st;
    timer_cmd_t tcmd;

    lpc_deglitch #(.STABLE_CYC(FILT_CYC)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  (res_n),
        .filt (res_f)
    );

    lpc_wake_timer #(.RES_WAIT(RES_WAIT_CYC), .STBY_WAIT(STBY_WAIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .cmd  (tcmd),
        .done (wait_done)
    );

    lpc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .is_master  (is_master),
        .res_ok     (res_f),
        .stby_n     (stby_n),
        .link_sleep (link_sleep),
        .link_wake  (link_wake),
        .wait_done  (wait_done),
        .state      (st),
        .tcmd       (tcmd)
    );

    lpc_out_force #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .NWCLK(NWCLK)) u_force (
        .clk       (clk),
        .rst       (rst),
        .is_master (is_master),
        .state     (st),
        .dat_in    (dat_in),
        .ctl_in    (ctl_in),
        .wclk_in   (wclk_in),
        .dat_out   (dat_out),
        .ctl_out   (ctl_out),
        .wclk_out  (wclk_out),
        .out_en    (out_en)
    );

    assign ready        = (st == PS_RUN);
    assign osc_en       = port_live(st);
    assign strobe_ok    = strobe_in &  ready;
    assign strobe_early = strobe_in & ~ready;

    // checker state: warm-up length and its origin
    logic [TW-1:0] chk_wake_cyc;
    logic          chk_from_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wake_cyc <= '0;
            chk_from_off <= 1'b1;
        end else begin
            chk_wake_cyc <= (st == PS_WAKE) ? chk_wake_cyc + 1'b1 : '0;
            if (st == PS_OFF)        chk_from_off <= 1'b1;
            else if (st == PS_SLEEP) chk_from_off <= 1'b0;
        end
    end

    // R1: a low filtered request always lands in off
    p_reset_dominant_r1: assert property (@(posedge clk) disable iff (rst)
        !res_f |=> (st == PS_OFF));

    // R8: warm-up length matches its origin
    p_wait_len_r8: assert property (@(posedge clk) disable iff (rst)
        (st == PS_RUN && $past(st) == PS_WAKE)
            |-> ($past(chk_wake_cyc) == (chk_from_off ? RES_LAST : STBY_LAST)));

    // R9: an accepted strobe is never also flagged, and needs the oscillator
    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (rst)
        strobe_ok |-> (!strobe_early && osc_en));

endmodule

// File: tb/lpc_top_bench.sv
module lpc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 18;
    localparam int CW   = 8;
    localparam int NW   = 2;
    localparam int FILT = 4;
    localparam int RW   = 10;
    localparam int SW   = 6;
    localparam int NV   = 6;

    // fields: dat[28:11] ctl[10:3] wclk[2:1] strobe[0]
    localparam logic [28:0] VEC [NV] = '{
        {18'h00000, 8'h00, 2'b00, 1'b0},
        {18'h3FFFF, 8'hFF, 2'b11, 1'b1},
        {18'h2A5A5, 8'h5A, 2'b01, 1'b0},
        {18'h15A5A, 8'hA5, 2'b10, 1'b1},
        {18'h00001, 8'h80, 2'b01, 1'b1},
        {18'h20000, 8'h01, 2'b10, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, is_master, res_n, stby_n, link_sleep, link_wake, strobe_in;
    logic [DW-1:0] dat_in;
    logic [CW-1:0] ctl_in;
    logic [NW-1:0] wclk_in;
    logic strobe_ok, strobe_early, ready, osc_en, out_en;
    logic [DW-1:0] dat_out;
    logic [CW-1:0] ctl_out;
    logic [NW-1:0] wclk_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_top #(.DATA_W(DW), .CTRL_W(CW), .NWCLK(NW), .FILT_CYC(FILT),
              .RES_WAIT_CYC(RW), .STBY_WAIT_CYC(SW)) u_lpc_top (
        .clk(clk), .rst(rst), .is_master(is_master), .res_n(res_n), .stby_n(stby_n),
        .link_sleep(link_sleep), .link_wake(link_wake), .strobe_in(strobe_in),
        .dat_in(dat_in), .ctl_in(ctl_in), .wclk_in(wclk_in),
        .strobe_ok(strobe_ok), .strobe_early(strobe_early), .ready(ready),
        .osc_en(osc_en), .out_en(out_en), .dat_out(dat_out), .ctl_out(ctl_out),
        .wclk_out(wclk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // from a negedge where res_n is high and the filter is still low
    task automatic bring_up();
        tick(FILT + 1);
        check("R10 osc_en in warm-up", 32'(osc_en), 32'd1);
        check("R8 not ready in warm-up", 32'(ready), 32'd0);
        strobe_in = 1'b1; #1;
        check("R9 early strobe flagged", 32'(strobe_early), 32'd1);
        check("R9 early strobe not accepted", 32'(strobe_ok), 32'd0);
        strobe_in = 1'b0;
        tick(RW - 1);
        check("R8 reset wait not yet over", 32'(ready), 32'd0);
        tick(1);
        check("R8 ready after reset wait", 32'(ready), 32'd1);
    endtask

    task automatic walk_vectors(input logic exp_en);
        for (int i = 0; i < NV; i++) begin
            dat_in    = VEC[i][28:11];
            ctl_in    = VEC[i][10:3];
            wclk_in   = VEC[i][2:1];
            strobe_in = VEC[i][0];
            #1;
            check("R11 data pass", 32'(dat_out), 32'(VEC[i][28:11]));
            check("R11 ctl pass", 32'(ctl_out), 32'(VEC[i][10:3]));
            check("R11 wclk pass", 32'(wclk_out), 32'(VEC[i][2:1]));
            check("R9 strobe accepted", 32'(strobe_ok), 32'(VEC[i][0]));
            check("R9 no early flag", 32'(strobe_early), 32'd0);
            check("R5 out_en live", 32'(out_en), 32'(exp_en));
            tick(1);
        end
        strobe_in = 1'b0;
    endtask

    initial begin
        rst = 1'b1; is_master = 1'b0; res_n = 1'b0; stby_n = 1'b1;
        link_sleep = 1'b0; link_wake = 1'b0; strobe_in = 1'b0;
        dat_in = '0; ctl_in = '0; wclk_in = '0;
        tick(3);
        // slave reset state
        check("R6 slave off data", 32'(dat_out), 32'd0);
        check("R6 slave off ctl", 32'(ctl_out), 32'd0);
        check("R6 slave off wclk high", 32'(wclk_out), 32'd3);
        check("R6 slave off drives", 32'(out_en), 32'd1);
        check("R1 off not ready", 32'(ready), 32'd0);
        check("R10 off osc", 32'(osc_en), 32'd0);

        @(negedge clk); rst = 1'b0; res_n = 1'b1;
        bring_up();
        walk_vectors(1'b1);

        // R4: slave ignores the standby pin
        stby_n = 1'b0;
        tick(3);
        check("R4 slave ignores stby_n", 32'(ready), 32'd1);
        stby_n = 1'b1;

        // R7: slave sleep holds values from the entry edge
        @(negedge clk);
        dat_in = 18'h2A5A5; ctl_in = 8'hC3; link_sleep = 1'b1;
        @(negedge clk);
        link_sleep = 1'b0; dat_in = 18'h15A5A; ctl_in = 8'h3C; #1;
        check("R7 sleep holds data", 32'(dat_out), 32'h2A5A5);
        check("R7 sleep holds ctl", 32'(ctl_out), 32'hC3);
        check("R7 sleep wclk high", 32'(wclk_out), 32'd3);
        check("R10 sleep osc off", 32'(osc_en), 32'd0);
        tick(3);
        check("R7 hold persists", 32'(dat_out), 32'h2A5A5);

        // R4/R8: link wake and standby wait
        @(negedge clk); link_wake = 1'b1;
        @(negedge clk); link_wake = 1'b0; #1;
        check("R4 link wake enters warm-up", 32'(osc_en), 32'd1);
        check("R11 warm-up pass-through", 32'(dat_out), 32'h15A5A);
        tick(SW - 1);
        check("R8 standby wait not yet over", 32'(ready), 32'd0);
        tick(1);
        check("R8 ready after standby wait", 32'(ready), 32'd1);

        // R2: short reset pulse rejected
        @(negedge clk); res_n = 1'b0;
        tick(FILT - 1);
        res_n = 1'b1;
        tick(4);
        check("R2 short pulse rejected", 32'(ready), 32'd1);

        // R2/R1/R6: pulse of exactly the window
        @(negedge clk); res_n = 1'b0;
        tick(FILT);
        check("R2 still running at window end", 32'(ready), 32'd1);
        link_wake = 1'b1;
        tick(1);
        check("R1 off after filtered fall", 32'(ready), 32'd0);
        check("R6 reset data low", 32'(dat_out), 32'd0);
        check("R6 reset wclk high", 32'(wclk_out), 32'd3);
        tick(1);
        link_wake = 1'b0;
        check("R1 link wake ignored in off", 32'(osc_en), 32'd0);

        // master role
        @(negedge clk); rst = 1'b1; is_master = 1'b1; res_n = 1'b1; stby_n = 1'b1;
        dat_in = 18'h3FFFF; ctl_in = 8'hFF; wclk_in = 2'b11;
        tick(2);
        check("R5 master off disabled", 32'(out_en), 32'd0);
        check("R5 master off data", 32'(dat_out), 32'd0);
        check("R5 master off wclk", 32'(wclk_out), 32'd0);
        @(negedge clk); rst = 1'b0;
        bring_up();
        walk_vectors(1'b1);

        // R3/R5: standby pin
        dat_in = 18'h3FFFF; ctl_in = 8'hFF; wclk_in = 2'b11;
        @(negedge clk); stby_n = 1'b0;
        tick(1);
        check("R3 master sleeps on pin", 32'(osc_en), 32'd0);
        check("R5 master sleep disabled", 32'(out_en), 32'd0);
        check("R5 master sleep data", 32'(dat_out), 32'd0);
        check("R5 master sleep ctl", 32'(ctl_out), 32'd0);
        link_wake = 1'b1;
        tick(2);
        link_wake = 1'b0;
        check("R3 master ignores link wake", 32'(osc_en), 32'd0);
        stby_n = 1'b1;
        tick(1);
        check("R3 master warm-up after pin", 32'(osc_en), 32'd1);
        check("R5 master warm-up drives", 32'(out_en), 32'd1);
        tick(SW - 1);
        check("R8 master standby wait", 32'(ready), 32'd0);
        tick(1);
        check("R3 master running", 32'(ready), 32'd1);

        // R1: reset beats standby pin
        @(negedge clk); res_n = 1'b0; stby_n = 1'b0;
        tick(FILT + 1);
        check("R1 master off", 32'(osc_en), 32'd0);
        check("R5 master reset disabled", 32'(out_en), 32'd0);
        stby_n = 1'b1;
        tick(5);
        check("R1 stby_n ignored in off", 32'(osc_en), 32'd0);
        check("R1 not ready in off", 32'(ready), 32'd0);

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule